// File: doc/BRIEF.md
# Sparse-Carry 36-Bit Adder Slice with Conditional Sums

This block is one 36-bit slice of a wide sparse-tree adder. It forms a carry only at the boundary of every nine-bit group. Inside each group, two candidate sums are built in parallel: one for a group carry-in of 0 and one for a carry-in of 1. The boundary carry then picks one of the two. The carries inside a group come from a local lookahead network rather than a ripple chain. For that reason, making the groups wider does not put the conditional-sum path on the critical path.

The slice takes two 36-bit operands and a carry-in. It returns:
- the 36-bit sum;
- the carry-out;
- a block generate and a block propagate, so that a parent tree can chain three slices into a 108-bit adder.

Across the boundary chain, the carry a group produces when its carry-in is 1 is used in place of the group propagate term. This is valid because that carry equals the carry-in-0 carry OR the prefix propagate.

The arithmetic is combinational. The results are captured in output registers, which are cleared by a synchronous active-high reset. This gives one clock of latency from the inputs to the outputs.

Top module: `sla_slice`

## Requirements
- R1: On a clock edge with `rst` high, `sum_q`, `cout_q`, `blk_g_q` and `blk_p_q` all become 0.
- R2: Inputs applied before a clock edge (with `rst` low) appear on the outputs after that edge. Before that edge, the outputs keep their previous values.
- R3: `{cout_q, sum_q}` equals the 37-bit value `a_in + b_in + cin` of the inputs captured at the previous edge.
- R4: `blk_g_q` is 1 exactly when `a_in + b_in` (with the carry-in taken as 0) is at least 2^36.
- R5: `blk_p_q` is 1 exactly when every bit of `a_in ^ b_in` is 1. `blk_g_q` and `blk_p_q` are never both 1.
- R6: `cout_q` equals `blk_g_q | (blk_p_q & cin)`, where `cin` is the carry-in captured at the same edge.
- R7: When every bit position propagates (`a_in ^ b_in` all ones), the carry-in crosses all four groups. With `cin` = 1, `sum_q` is 0 and `cout_q` is 1. With `cin` = 0, `sum_q` is all ones and `cout_q` is 0.
- R8: A lone carry generated at the top bit of a group crosses the nine-bit boundaries above it. The generating bit is one of bits 8, 17, 26 and 35, with both operand bits set there. The bits above it propagate. The resulting sum and carry-out match R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 36 | First operand |
| b_in | input | 36 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum_q | output | 36 | Registered sum |
| blk_g_q | output | 1 | Registered block generate |
| blk_p_q | output | 1 | Registered block propagate |
| cout_q | output | 1 | Registered carry-out of bit 35 |

## Verification
The bench drives the all-propagate operand pair with both values of the carry-in. A design whose boundary mux or lookahead drops the carry-in-1 path leaves upper groups one short, so the sum is not zero. It places a single generate at the top bit of each group, with propagates above it. A selection wired to the wrong group boundary puts the carry into the wrong nine-bit field, or loses it.

Random operands, all-zero and all-one operands, and a back-to-back latency check round this out. An off-by-one in the local prefix terms would show up as corrupted sum bits. A wrongly combined block generate or propagate would show up as a carry-out that disagrees with the arithmetic sum.

// File: rtl/sla_pkg.sv
package sla_pkg;
  localparam int unsigned SLICE_W_DEF = 36;
  localparam int unsigned GROUP_W_DEF = 9;
endpackage

// File: rtl/sla_bitpg.sv
module sla_bitpg #(
  parameter int unsigned W = sla_pkg::SLICE_W_DEF
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] g,
  output logic [W-1:0] p
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign g[i] = a[i] & b[i];
    assign p[i] = a[i] ^ b[i];
  end
endmodule

// File: rtl/sla_cond_group.sv
module sla_cond_group #(
  parameter int unsigned GW = sla_pkg::GROUP_W_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [GW-1:0] g,
  input  logic [GW-1:0] p,
  input  logic          c_sel,
  output logic [GW-1:0] sum,
  output logic          grp_g,
  output logic          grp_p,
  output logic          grp_c1
);
  logic [GW:0]   c0, c1, pp;
  logic [GW-1:0] s0, s1;
  logic          run;

  // Local lookahead: each internal carry is a flat OR of generate terms
  // gated by the propagates between them, with no ripple dependency.
  always_comb begin
    pp[0] = 1'b1;
    c0[0] = 1'b0;
    run   = 1'b0;
    for (int i = 1; i <= GW; i++) begin
      pp[i] = pp[i-1] & p[i-1];
      c0[i] = 1'b0;
      for (int j = 0; j < i; j++) begin
        run = g[j];
        for (int k = j + 1; k < i; k++) begin
          run = run & p[k];
        end
        c0[i] = c0[i] | run;
      end
    end
    c1 = c0 | pp;
  end

  assign s0 = p ^ c0[GW-1:0];
  assign s1 = p ^ c1[GW-1:0];

  for (genvar i = 0; i < GW; i++) begin : g_sel
    assign sum[i] = c_sel ? s1[i] : s0[i];
  end

  assign grp_g  = c0[GW];
  assign grp_p  = pp[GW];
  assign grp_c1 = c1[GW];

  AST_GRP_SUM0: assert property (@(posedge clk) disable iff (rst)
    {grp_g, s0} == ({1'b0, p} + {g, 1'b0})); // R3
  AST_GRP_SUM1: assert property (@(posedge clk) disable iff (rst)
    {grp_c1, s1} == ({1'b0, p} + {g, 1'b0} + (GW+1)'(1))); // R3
  AST_GRP_GP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(grp_g && grp_p)); // R5
endmodule

// File: rtl/sla_sparse_tree.sv
module sla_sparse_tree #(
  parameter int unsigned NG = 4
) (
  input  logic          cin,
  input  logic [NG-1:0] gg,
  input  logic [NG-1:0] gp,
  input  logic [NG-1:0] gc1,
  output logic [NG-1:0] bnd_c,
  output logic          blk_g,
  output logic          blk_p,
  output logic          cout
);
  logic [NG:0] z, o;
  logic        run;

  always_comb begin
    z[0] = 1'b0;
    o[0] = 1'b1;
    run  = 1'b0;
    for (int k = 1; k <= NG; k++) begin
      z[k] = 1'b0;
      for (int j = 0; j < k; j++) begin
        run = gg[j];
        for (int m = j + 1; m < k; m++) begin
          run = run & gp[m];
        end
        z[k] = z[k] | run;
      end
      // The carry-in-1 group carry stands in for the propagate term.
      o[k] = o[k-1] ? gc1[k-1] : gg[k-1];
    end
  end

  for (genvar k = 0; k < NG; k++) begin : g_bnd
    assign bnd_c[k] = cin ? o[k] : z[k];
  end

  assign blk_g = z[NG];
  assign blk_p = &gp;
  assign cout  = cin ? o[NG] : z[NG];
endmodule

// File: rtl/sla_slice.sv
module sla_slice #(
  parameter int unsigned W  = sla_pkg::SLICE_W_DEF,
  parameter int unsigned GW = sla_pkg::GROUP_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         cin,
  output logic [W-1:0] sum_q,
  output logic         blk_g_q,
  output logic         blk_p_q,
  output logic         cout_q
);
  localparam int unsigned NG = W / GW;
  localparam int unsigned XW = W + 1;

  logic [W-1:0]  g, p, sum_d;
  logic [NG-1:0] gg, gp, gc1, bnd_c;
  logic          blk_g, blk_p, cout;
  logic          armed_q;

  sla_bitpg #(.W(W)) u_pg (.a(a_in), .b(b_in), .g(g), .p(p));

  for (genvar k = 0; k < NG; k++) begin : g_grp
    sla_cond_group #(.GW(GW)) u_grp (
      .clk    (clk),
      .rst    (rst),
      .g      (g[k*GW +: GW]),
      .p      (p[k*GW +: GW]),
      .c_sel  (bnd_c[k]),
      .sum    (sum_d[k*GW +: GW]),
      .grp_g  (gg[k]),
      .grp_p  (gp[k]),
      .grp_c1 (gc1[k])
    );
  end

  sla_sparse_tree #(.NG(NG)) u_tree (
    .cin   (cin),
    .gg    (gg),
    .gp    (gp),
    .gc1   (gc1),
    .bnd_c (bnd_c),
    .blk_g (blk_g),
    .blk_p (blk_p),
    .cout  (cout)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q   <= '0;
      blk_g_q <= 1'b0;
      blk_p_q <= 1'b0;
      cout_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      sum_q   <= sum_d;
      blk_g_q <= blk_g;
      blk_p_q <= blk_p;
      cout_q  <= cout;
      armed_q <= 1'b1;
    end
  end

  AST_RST_CLEAR: assert property (@(posedge clk)
    rst |=> (sum_q == '0 && !cout_q && !blk_g_q && !blk_p_q)); // R1
  AST_SUM_ARITH: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> ({cout_q, sum_q} ==
      ({1'b0, $past(a_in)} + {1'b0, $past(b_in)} + XW'($past(cin))))); // R3
  AST_CARRY_FORM: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (cout_q == (blk_g_q | (blk_p_q & $past(cin))))); // R6
  AST_PROP_RIPPLE: assert property (@(posedge clk) disable iff (rst)
    (armed_q && blk_p_q) |->
      (cout_q == $past(cin) && sum_q == {W{~$past(cin)}})); // R7
endmodule

// File: tb/sla_slice_tb.sv
module sla_slice_tb_top;
  localparam int unsigned W     = 36;
  localparam int unsigned CLK_P = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum_q;
  logic         blk_g_q, blk_p_q, cout_q;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  sla_slice #(.W(W), .GW(9)) dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .cin(cin),
    .sum_q(sum_q), .blk_g_q(blk_g_q), .blk_p_q(blk_p_q), .cout_q(cout_q)
  );

  task automatic chk(input string req, input logic [W:0] act, input logic [W:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one vector, clock it in, then check all outputs.
  task automatic apply(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic c);
    logic [W:0] tot;
    logic [W:0] tot0;
    @(negedge clk);
    a_in = a; b_in = b; cin = c;
    @(negedge clk);
    tot  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    tot0 = {1'b0, a} + {1'b0, b};
    chk({req, " R3 sum"}, {cout_q, sum_q}, tot);
    chk({req, " R4 blk_g"}, {{W{1'b0}}, blk_g_q}, {{W{1'b0}}, tot0[W]});
    chk({req, " R5 blk_p"}, {{W{1'b0}}, blk_p_q}, {{W{1'b0}}, &(a ^ b)});
    chk({req, " R6 cout"}, {{W{1'b0}}, cout_q},
        {{W{1'b0}}, tot0[W] | (&(a ^ b) & c)});
  endtask

  task automatic t_reset;
    @(negedge clk);
    a_in = '1; b_in = '1; cin = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clear", {cout_q, sum_q}, '0);
    chk("R1 reset g/p", {{(W-1){1'b0}}, blk_g_q, blk_p_q}, '0);
    rst = 1'b0;
  endtask

  task automatic t_latency;
    logic [W-1:0] prev;
    apply("R2 first", 36'h0_0000_0005, 36'h0_0000_0003, 1'b0);
    prev = sum_q;
    @(negedge clk);
    a_in = 36'h1_2345_6789; b_in = 36'h0_1111_1111; cin = 1'b1;
    #1;
    chk("R2 hold before edge", {1'b0, sum_q}, {1'b0, prev});
    @(negedge clk);
    chk("R2 after edge", {cout_q, sum_q}, 37'h1_2345_6789 + 37'h0_1111_1111 + 37'd1);
  endtask

  task automatic t_all_prop;
    logic [W-1:0] pat = 36'hA_5A5A_5A5A;
    apply("R7 cin1", pat, ~pat, 1'b1);
    chk("R7 cin1 sum zero", {cout_q, sum_q}, {1'b1, {W{1'b0}}});
    apply("R7 cin0", pat, ~pat, 1'b0);
    chk("R7 cin0 sum ones", {cout_q, sum_q}, {1'b0, {W{1'b1}}});
    apply("R7 ones+zero", '1, '0, 1'b1);
  endtask

  task automatic t_boundary;
    for (int k = 0; k < 4; k++) begin
      logic [W-1:0] a, b, above;
      int bit_i = 9 * k + 8;
      above = ({W{1'b1}} << (bit_i + 1));
      a = above | (36'd1 << bit_i);
      b = (36'd1 << bit_i);
      apply("R8 gen at boundary", a, b, 1'b0);
      apply("R8 gen at boundary cin", a, b, 1'b1);
      apply("R8 gen no prop above", 36'd1 << bit_i, 36'd1 << bit_i, 1'b0);
    end
  endtask

  task automatic t_random;
    for (int n = 0; n < 300; n++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = {$urandom, $urandom};
      apply("R3 random", ra[W-1:0], rb[W-1:0], 1'($urandom));
    end
  endtask

  task automatic t_extremes;
    apply("R3 zeros", '0, '0, 1'b0);
    apply("R3 zeros cin", '0, '0, 1'b1);
    apply("R4 max+max", '1, '1, 1'b1);
    apply("R4 max+1", '1, 36'd1, 1'b0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_latency();
    t_all_prop();
    t_boundary();
    t_extremes();
    t_random();
    t_reset();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule